// File: doc/BRIEF.md
# Mixed-Trigger Interrupt Request Front-End

This block conditions raw interrupt requests before they reach a CPU trap unit. Each group of inputs follows its own trigger discipline. There is one non-maskable request, detected on an edge, that no enable can block. Three machine-level requests (timer, software, external) are level-sensitive: the source holds each one high until it is acknowledged elsewhere. Sixteen fast channels fire on a single rising edge and need no acknowledgment from the source. A 32-bit vector of platform request lines is folded onto one of the fast channels.

Every input passes through a two-flop synchronizer. Edge-triggered channels latch a pending bit, and the bit stays set until the CPU clears it through the clear port. Level channels have no storage: their pending output is the synchronized input ANDed with its enable. Fast channels 12 to 15 are reserved and never become pending. Channels 10 and 11 carry the stream-link receive and transmit events. Software reads the pending outputs, and for the folded channel it polls its own platform sources to find out which external line fired.

Top module: `irq_frontend`

## Requirements
- R1: While `rstN` is low, and after it is released with all inputs low, `nmiPend`, `machPend` and `fastPend` are all zero.
- R2: A fast input sampled high at one rising clock edge, after being low at the previous edge, sets its `fastPend` bit at the third rising edge from the sampling edge. A pulse one clock cycle wide is enough. Channels 10 and 11 behave like every other ordinary channel.
- R3: A set fast pending bit stays set with no acknowledgment from the source. Asserting bit k of `clrFast` for one cycle clears bit k at the next rising edge. If a new edge and a clear meet on the same edge, the bit ends up set.
- R4: `fastPend[k]` is the latched state ANDed with `fastEnable[k]`, and a change of the enable shows without delay. An edge that arrives while its channel is disabled is kept, and the bit shows once the enable returns.
- R5: `fastPend[15:12]` is zero at all times, whatever `fastIn[15:12]` does.
- R6: Channel 8 is the fold channel. It takes its edge from the OR of the synchronized `fastIn[8]` and all 32 bits of `extIn`. If a second external line rises while another one is still high, no new event occurs.
- R7: `machPend` (bit 0 timer, bit 1 software, bit 2 external) equals `machIn` as sampled two rising edges earlier, ANDed with the current `machEnable`. It keeps no state.
- R8: A rising edge on `nmiIn` sets `nmiPend` at the third rising edge, whatever the enables are. `nmiPend` stays set until `clrNmi` clears it at the next edge. While `nmiIn` stays high, the clear is not followed by a new set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rstN | input | 1 | asynchronous reset, active low |
| nmiIn | input | 1 | non-maskable request, rising-edge |
| machIn | input | 3 | machine requests, level, active high (timer, software, external) |
| fastIn | input | 16 | fast peripheral requests, one-cycle pulses |
| extIn | input | 32 | platform external request lines |
| machEnable | input | 3 | enables for the machine requests |
| fastEnable | input | 16 | enables for the fast channels |
| clrFast | input | 16 | per-channel clear of fast pending bits |
| clrNmi | input | 1 | clear of the non-maskable pending bit |
| nmiPend | output | 1 | non-maskable request pending |
| machPend | output | 3 | machine requests pending |
| fastPend | output | 16 | fast channels pending |

## Verification
The assertions assume that every input changes only between clock edges and holds low while reset is active. On that basis, the sampled history over the last four edges reflects real input values, and it is not the state before reset. The stimulus drives all lines just after a falling edge and keeps them at zero during reset. Fast requests are one-cycle pulses, and level and external lines are held for several cycles. The non-maskable and machine checks therefore compare against input values that the synchronizers actually captured.

// File: rtl/irq_frontend_pkg.sv
package irq_frontend_pkg;
  localparam int FAST_N   = 16;
  localparam int EXT_N    = 32;
  localparam int MACH_N   = 3;
  localparam int EXT_CHAN = 8;
  localparam int RSVD_LO  = 12;
  localparam int SYNC_STAGES = 2;

  typedef struct packed {
    logic [FAST_N-1:0] fastSet;
    logic [FAST_N-1:0] fastClr;
    logic              nmiSet;
    logic              nmiClr;
  } strobe_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_frontend_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiSync,
  input  logic [FAST_N-1:0] fastSync,
  input  logic [EXT_N-1:0]  extSync,
  input  logic [FAST_N-1:0] clrFast,
  input  logic              clrNmi,
  output strobe_t           strobe
);
  logic [FAST_N-1:0] fastMerged;
  logic [FAST_N-1:0] fastPrev;
  logic              nmiPrev;
  logic              extAny;

  assign extAny = |extSync;

  genvar ch;
  generate
    for (ch = 0; ch < FAST_N; ch++) begin : g_chan
      if (ch >= RSVD_LO) begin : g_rsvd
        assign fastMerged[ch] = 1'b0;
      end else if (ch == EXT_CHAN) begin : g_fold
        assign fastMerged[ch] = fastSync[ch] | extAny;
      end else begin : g_plain
        assign fastMerged[ch] = fastSync[ch];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastPrev <= '0;
      nmiPrev  <= 1'b0;
    end else begin
      fastPrev <= fastMerged;
      nmiPrev  <= nmiSync;
    end
  end

  always_comb begin
    strobe.fastSet = fastMerged & ~fastPrev;
    strobe.nmiSet  = nmiSync & ~nmiPrev;
    strobe.fastClr = clrFast;
    strobe.nmiClr  = clrNmi;
  end
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_frontend_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [MACH_N-1:0] machSync,
  input  logic [MACH_N-1:0] machEnable,
  input  logic [FAST_N-1:0] fastEnable,
  output logic              nmiPend,
  output logic [MACH_N-1:0] machPend,
  output logic [FAST_N-1:0] fastPend
);
  logic [FAST_N-1:0] fastLatch;
  logic              nmiLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastLatch <= '0;
      nmiLatch  <= 1'b0;
    end else begin
      fastLatch <= (fastLatch & ~strobe.fastClr) | strobe.fastSet;
      nmiLatch  <= (nmiLatch & ~strobe.nmiClr) | strobe.nmiSet;
    end
  end

  assign nmiPend  = nmiLatch;
  assign machPend = machSync & machEnable;
  assign fastPend = fastLatch & fastEnable;
endmodule

// File: rtl/irq_frontend.sv
module irq_frontend
  import irq_frontend_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              nmiIn,
  input  logic [MACH_N-1:0] machIn,
  input  logic [FAST_N-1:0] fastIn,
  input  logic [EXT_N-1:0]  extIn,
  input  logic [MACH_N-1:0] machEnable,
  input  logic [FAST_N-1:0] fastEnable,
  input  logic [FAST_N-1:0] clrFast,
  input  logic              clrNmi,
  output logic              nmiPend,
  output logic [MACH_N-1:0] machPend,
  output logic [FAST_N-1:0] fastPend
);
  logic              nmiSync;
  logic [MACH_N-1:0] machSync;
  logic [FAST_N-1:0] fastSync;
  logic [EXT_N-1:0]  extSync;
  strobe_t           strobe;

  irq_sync #(.W(1), .STAGES(SYNC_STAGES)) uNmiSync (
    .clk(clk), .rstN(rstN), .d(nmiIn), .q(nmiSync));
  irq_sync #(.W(MACH_N), .STAGES(SYNC_STAGES)) uMachSync (
    .clk(clk), .rstN(rstN), .d(machIn), .q(machSync));
  irq_sync #(.W(FAST_N), .STAGES(SYNC_STAGES)) uFastSync (
    .clk(clk), .rstN(rstN), .d(fastIn), .q(fastSync));
  irq_sync #(.W(EXT_N), .STAGES(SYNC_STAGES)) uExtSync (
    .clk(clk), .rstN(rstN), .d(extIn), .q(extSync));

  irq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .nmiSync(nmiSync), .fastSync(fastSync),
    .extSync(extSync), .clrFast(clrFast), .clrNmi(clrNmi), .strobe(strobe));

  irq_datapath uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .machSync(machSync),
    .machEnable(machEnable), .fastEnable(fastEnable),
    .nmiPend(nmiPend), .machPend(machPend), .fastPend(fastPend));
endmodule

// File: rtl/irq_frontend_chk.sv
module irq_frontend_chk
  import irq_frontend_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              nmiIn,
  input logic [MACH_N-1:0] machIn,
  input logic [MACH_N-1:0] machEnable,
  input logic [FAST_N-1:0] fastEnable,
  input logic [FAST_N-1:0] clrFast,
  input logic              clrNmi,
  input logic              nmiPend,
  input logic [MACH_N-1:0] machPend,
  input logic [FAST_N-1:0] fastPend
);
  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rstN)
    fastPend[FAST_N-1:RSVD_LO] == '0);

  a_r3_fast_hold: assert property (@(posedge clk) disable iff (!rstN)
    (clrFast == '0) |=> (($past(fastPend) & (fastPend | ~fastEnable)) == $past(fastPend)));

  a_r8_nmi_hold: assert property (@(posedge clk) disable iff (!rstN)
    (nmiPend && !clrNmi) |=> nmiPend);

  a_r8_nmi_edge: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nmiPend) |-> ($past(nmiIn, 3) && !$past(nmiIn, 4)));

  a_r7_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    machPend == ($past(machIn, 2) & machEnable));
endmodule

bind irq_frontend irq_frontend_chk uChk (
  .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .machIn(machIn),
  .machEnable(machEnable), .fastEnable(fastEnable), .clrFast(clrFast),
  .clrNmi(clrNmi), .nmiPend(nmiPend), .machPend(machPend), .fastPend(fastPend));

// File: tb/irq_frontend_test.sv
`timescale 1ns/1ps
module irq_frontend_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        nmiIn = 1'b0;
  logic [2:0]  machIn = '0;
  logic [15:0] fastIn = '0;
  logic [31:0] extIn = '0;
  logic [2:0]  machEnable = 3'b111;
  logic [15:0] fastEnable = 16'hFFFF;
  logic [15:0] clrFast = '0;
  logic        clrNmi = 1'b0;
  logic        nmiPend;
  logic [2:0]  machPend;
  logic [15:0] fastPend;

  irq_frontend uut (
    .clk(clk), .rstN(rstN), .nmiIn(nmiIn), .machIn(machIn), .fastIn(fastIn),
    .extIn(extIn), .machEnable(machEnable), .fastEnable(fastEnable),
    .clrFast(clrFast), .clrNmi(clrNmi), .nmiPend(nmiPend),
    .machPend(machPend), .fastPend(fastPend));

  always #4 clk = ~clk;

  typedef struct {
    int          when;
    logic        n;
    logic [2:0]  m;
    logic [15:0] f;
    string       req;
  } exp_t;

  exp_t scoreQ[$];
  int   cyc = 0;
  int   applied = 0;
  int   bad = 0;
  bit   done = 0;

  always @(posedge clk) cyc = cyc + 1;

  always @(negedge clk) begin
    while (scoreQ.size() > 0 && scoreQ[0].when <= cyc) begin
      exp_t e;
      e = scoreQ.pop_front();
      applied++;
      if (e.when != cyc || nmiPend !== e.n || machPend !== e.m || fastPend !== e.f) begin
        bad++;
        $display("FAIL %s: got nmi=%b mach=%b fast=%h, expected nmi=%b mach=%b fast=%h",
                 e.req, nmiPend, machPend, fastPend, e.n, e.m, e.f);
      end
    end
  end

  task automatic expectAt(int dly, logic n, logic [2:0] m, logic [15:0] f, string req);
    exp_t e;
    e.when = cyc + dly; e.n = n; e.m = m; e.f = f; e.req = req;
    scoreQ.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      finishRun();
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    // R1 reset state
    expectAt(1, 0, 3'b000, 16'h0000, "R1");
    tick(2);

    // R2 one-cycle pulse on channel 3, latency of three edges
    fastIn[3] = 1'b1;
    expectAt(2, 0, 3'b000, 16'h0000, "R2");
    expectAt(3, 0, 3'b000, 16'h0008, "R2");
    expectAt(7, 0, 3'b000, 16'h0008, "R3");
    tick(1); fastIn = '0; tick(8);
    // R3 clear
    clrFast = 16'h0008;
    expectAt(1, 0, 3'b000, 16'h0000, "R3");
    tick(1); clrFast = '0; tick(3);

    // R5 reserved channels
    fastIn = 16'hA000;
    expectAt(3, 0, 3'b000, 16'h0000, "R5");
    expectAt(6, 0, 3'b000, 16'h0000, "R5");
    tick(1); fastIn = '0; tick(8);

    // R2 stream-link channels
    fastIn = 16'h0C00;
    expectAt(3, 0, 3'b000, 16'h0C00, "R2");
    tick(1); fastIn = '0; tick(4);
    clrFast = 16'h0C00;
    expectAt(1, 0, 3'b000, 16'h0000, "R3");
    tick(1); clrFast = '0; tick(2);

    // R6 external fold onto channel 8
    extIn = 32'h0010_0000;
    expectAt(3, 0, 3'b000, 16'h0100, "R6");
    tick(4);
    clrFast = 16'h0100;
    expectAt(1, 0, 3'b000, 16'h0000, "R3");
    tick(1); clrFast = '0;
    extIn = 32'h0010_0001;
    expectAt(4, 0, 3'b000, 16'h0000, "R6");
    tick(6);
    extIn = '0; tick(3);
    extIn = 32'h0000_0001;
    expectAt(3, 0, 3'b000, 16'h0100, "R6");
    tick(4);
    extIn = '0; clrFast = 16'h0100;
    expectAt(1, 0, 3'b000, 16'h0000, "R3");
    tick(1); clrFast = '0; tick(3);

    // R4 masked edge kept, shown on re-enable
    fastEnable = 16'hFFDF;
    fastIn[5] = 1'b1;
    expectAt(3, 0, 3'b000, 16'h0000, "R4");
    expectAt(5, 0, 3'b000, 16'h0000, "R4");
    tick(1); fastIn = '0; tick(6);
    fastEnable = 16'hFFFF;
    expectAt(1, 0, 3'b000, 16'h0020, "R4");
    tick(2);
    clrFast = 16'h0020;
    expectAt(1, 0, 3'b000, 16'h0000, "R3");
    tick(1); clrFast = '0; tick(2);

    // R3 set beats clear on the same edge
    fastIn[1] = 1'b1;
    tick(1); fastIn = '0;
    tick(1);
    clrFast = 16'h0002;
    expectAt(1, 0, 3'b000, 16'h0002, "R3");
    tick(1); clrFast = '0;
    expectAt(3, 0, 3'b000, 16'h0002, "R3");
    tick(4);
    clrFast = 16'h0002;
    expectAt(1, 0, 3'b000, 16'h0000, "R3");
    tick(1); clrFast = '0; tick(2);

    // R7 level-sensitive machine requests
    machIn = 3'b101;
    expectAt(1, 0, 3'b000, 16'h0000, "R7");
    expectAt(2, 0, 3'b101, 16'h0000, "R7");
    tick(3);
    machEnable = 3'b011;
    expectAt(1, 0, 3'b001, 16'h0000, "R7");
    tick(2);
    machIn = '0; machEnable = 3'b111;
    expectAt(1, 0, 3'b101, 16'h0000, "R7");
    expectAt(2, 0, 3'b000, 16'h0000, "R7");
    tick(3);

    // R8 non-maskable edge with every enable off
    machEnable = '0; fastEnable = '0;
    nmiIn = 1'b1;
    expectAt(2, 0, 3'b000, 16'h0000, "R8");
    expectAt(3, 1, 3'b000, 16'h0000, "R8");
    tick(5);
    clrNmi = 1'b1;
    expectAt(1, 0, 3'b000, 16'h0000, "R8");
    tick(1); clrNmi = 1'b0;
    expectAt(4, 0, 3'b000, 16'h0000, "R8");
    tick(6);
    nmiIn = 1'b0; tick(3);
    machEnable = 3'b111; fastEnable = 16'hFFFF;
    expectAt(1, 0, 3'b000, 16'h0000, "R1");
    tick(4);

    if (scoreQ.size() != 0) begin
      bad++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", scoreQ.size());
    end
    done = 1;
    finishRun();
  end
endmodule